// File: doc/BRIEF.md
# Microwire Serial EEPROM Command Front End

This block is the serial slave side of a small nonvolatile memory reached over a three-wire Microwire link. It oversamples chip select, serial clock and data in with the system clock. It finds the start bit and collects the opcode and the address. It then decodes the command set and keeps the latch that permits programming. Reads are served straight from a behavioural array of 256 sixteen-bit words. Data goes out on a serial output with a separate enable, so the pad can be tri-stated.

Commands that change memory are never done in the front end. When chip select drops, it raises a request to an external program-cycle controller, which times the cell operation. The request carries the kind, the address and the data. When the controller answers with done, the array takes the new contents. A static strap picks between word-wide and byte-wide organization. Tied low, as it is when left open behind a pull-down, it gives word mode.

Top module: `mw_eeprom_front`

## Requirements
- R1: After reset the output enable is low, no program request is pending, and the program-enable latch is clear.
- R2: While chip select is high, zeros before the first 1 are skipped. That 1 is the start bit. Then come a 2-bit opcode and the address, MSB first. Data in is taken on each rising serial clock.
- R3: Opcode 10 is a read. On the rising clock edge that delivers the last address bit, the output enable goes high and the output drives a 0. Each later rising edge then drives one data bit, MSB first.
- R4: While chip select stays high, a read carries on into the next address with no further zero bit. After the top location it wraps to address 0.
- R5: With org_byte low, a command has 8 address bits and 16 data bits. With it high, there are 9 address bits and 8 data bits, and the address names a byte: address bit 0 = 0 selects bits 7..0 of a word, and 1 selects bits 15..8.
- R6: Opcode 01 with an address and data is a write. At chip-select fall it raises prog_req with prog_kind 0, the address and the data (a byte sits in bits 7..0). On prog_done the location takes the data.
- R7: Opcode 11 with an address is an erase: prog_kind 1. On prog_done the location (word or byte) becomes all ones.
- R8: Under opcode 00, the top two address bits select a sub-command: 11 sets the program-enable latch, 00 clears it, 10 requests erase-all (prog_kind 2, all words become all ones), and 01 with data requests write-all (prog_kind 3, every word takes the data).
- R9: While the program-enable latch is clear, write, erase, erase-all and write-all raise no request and leave the array unchanged. Reads work in either state.
- R10: prog_req, prog_kind and prog_addr stay steady until prog_done. A program command that ends while a request is still open is dropped.
- R11: Chip select low turns the output enable off and clears the bit count. A command cut short by chip select falling is discarded, and the next command decodes from a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org_byte | input | 1 | Organization strap: 0 word mode, 1 byte mode |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the data-out pad |
| prog_req | output | 1 | Program request to the cycle controller |
| prog_kind | output | 2 | 0 write, 1 erase, 2 erase-all, 3 write-all |
| prog_addr | output | 9 | Word address (word mode) or byte address (byte mode) |
| prog_data | output | 16 | Data to program |
| prog_done | input | 1 | Controller reports the cycle complete |

## Verification
The assertions assume a slow serial clock, with each level held for several system clocks. They assume data in is steady around each rising serial edge and that the strap changes only while chip select is low. The program controller is assumed to pulse done only while a request is open. The bench drives every serial level for at least three system clocks and sets data in two clocks before each rising edge. It moves the strap only with chip select low, and its controller model answers only an outstanding request. Under those conditions the bench exercises the dummy-bit framing, the wrap of sequential reads in both organizations, the enable gating, the dropped overlapping command and the aborted commands.

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk,
  input  logic          di,
  input  logic          org_byte,
  output logic          dout,
  output logic          dout_oe,
  output logic          prog_req,
  output logic [1:0]    prog_kind,
  output logic [AW:0]   prog_addr,
  output logic [DW-1:0] prog_data,
  input  logic          prog_done
);
  localparam int BW   = DW / 2;
  localparam int CW   = AW + 3;
  localparam int NW   = 1 << AW;
  localparam int CNTW = $clog2(CW + DW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_READ, S_HOLD} st_t;

  st_t              st;
  logic             cs_q, sk_q, sk_q2, di_q;
  logic             wen, mode_b, p_byte;
  logic [CNTW-1:0]  cnt;
  logic [CW-2:0]    cmd_sh;
  logic [DW-2:0]    dat_sh;
  logic             pend;
  logic [1:0]       pend_kind;
  logic [AW:0]      pend_addr;
  logic [DW-1:0]    pend_data;
  logic [AW:0]      rd_addr;
  logic [DW-1:0]    rd_sh;
  logic [DW-1:0]    mem [NW];

  wire              rise     = sk_q & ~sk_q2;
  wire [CW-1:0]     cmd_nx   = {cmd_sh, di_q};
  wire [DW-1:0]     dat_nx   = {dat_sh, di_q};
  wire [CNTW-1:0]   cmd_last = mode_b ? CNTW'(AW + 2) : CNTW'(AW + 1);
  wire [CNTW-1:0]   dat_last = mode_b ? CNTW'(BW - 1) : CNTW'(DW - 1);
  wire [1:0]        op       = mode_b ? cmd_nx[AW+2:AW+1] : cmd_nx[AW+1:AW];
  wire [AW:0]       adr      = mode_b ? cmd_nx[AW:0] : {1'b0, cmd_nx[AW-1:0]};
  wire [1:0]        ext      = mode_b ? cmd_nx[AW:AW-1] : cmd_nx[AW-1:AW-2];
  wire [AW:0]       rd_nx    = mode_b ? rd_addr + 1'b1 : {1'b0, rd_addr[AW-1:0] + 1'b1};
  wire              commit   = prog_req & prog_done;

  function automatic logic [DW-1:0] fetch(input logic [AW:0] a, input logic b);
    logic [DW-1:0] w;
    w = mem[b ? a[AW:1] : a[AW-1:0]];
    if (b) fetch = {(a[0] ? w[DW-1:BW] : w[BW-1:0]), {BW{1'b0}}};
    else   fetch = w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cs_q <= 1'b0; sk_q <= 1'b0; sk_q2 <= 1'b0; di_q <= 1'b0;
      wen <= 1'b0; mode_b <= 1'b0; p_byte <= 1'b0;
      cnt <= '0; cmd_sh <= '0; dat_sh <= '0;
      pend <= 1'b0; pend_kind <= '0; pend_addr <= '0; pend_data <= '0;
      rd_addr <= '0; rd_sh <= '0;
      dout <= 1'b0; dout_oe <= 1'b0;
      prog_req <= 1'b0; prog_kind <= '0; prog_addr <= '0; prog_data <= '0;
    end else begin
      cs_q  <= cs;
      sk_q  <= sk;
      sk_q2 <= sk_q;
      di_q  <= di;
      if (commit) prog_req <= 1'b0;
      if (!cs_q) begin
        st      <= S_IDLE;
        cnt     <= '0;
        dout    <= 1'b0;
        dout_oe <= 1'b0;
        mode_b  <= org_byte;
        if (pend) begin
          pend <= 1'b0;
          if (!prog_req) begin
            prog_req  <= 1'b1;
            prog_kind <= pend_kind;
            prog_addr <= pend_addr;
            prog_data <= pend_data;
            p_byte    <= mode_b;
          end
        end
      end else if (rise) begin
        unique case (st)
          S_IDLE: if (di_q) begin
            st  <= S_CMD;
            cnt <= '0;
          end
          S_CMD: begin
            cmd_sh <= cmd_nx[CW-2:0];
            cnt    <= cnt + 1'b1;
            if (cnt == cmd_last) begin
              cnt       <= '0;
              pend_addr <= adr;
              st        <= S_HOLD;
              case (op)
                2'b10: begin
                  st      <= S_READ;
                  dout_oe <= 1'b1;
                  dout    <= 1'b0;
                  rd_addr <= adr;
                  rd_sh   <= fetch(adr, mode_b);
                end
                2'b01: begin
                  st        <= S_DATA;
                  pend_kind <= 2'd0;
                end
                2'b11: begin
                  pend      <= wen;
                  pend_kind <= 2'd1;
                  pend_data <= '0;
                end
                default: case (ext)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b10: begin
                    pend      <= wen;
                    pend_kind <= 2'd2;
                    pend_data <= '0;
                  end
                  default: begin
                    st        <= S_DATA;
                    pend_kind <= 2'd3;
                  end
                endcase
              endcase
            end
          end
          S_DATA: begin
            dat_sh <= dat_nx[DW-2:0];
            cnt    <= cnt + 1'b1;
            if (cnt == dat_last) begin
              st        <= S_HOLD;
              pend      <= wen;
              pend_data <= mode_b ? {{BW{1'b0}}, dat_nx[BW-1:0]} : dat_nx;
            end
          end
          S_READ: begin
            dout <= rd_sh[DW-1];
            if (cnt == dat_last) begin
              cnt     <= '0;
              rd_addr <= rd_nx;
              rd_sh   <= fetch(rd_nx, mode_b);
            end else begin
              cnt   <= cnt + 1'b1;
              rd_sh <= rd_sh << 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  wire [AW-1:0] widx = p_byte ? prog_addr[AW:1] : prog_addr[AW-1:0];

  always_ff @(posedge clk) begin
    if (commit) begin
      case (prog_kind)
        2'd0, 2'd1: begin
          if (!p_byte)
            mem[widx] <= (prog_kind == 2'd1) ? {DW{1'b1}} : prog_data;
          else if (prog_addr[0])
            mem[widx][DW-1:BW] <= (prog_kind == 2'd1) ? {BW{1'b1}} : prog_data[BW-1:0];
          else
            mem[widx][BW-1:0] <= (prog_kind == 2'd1) ? {BW{1'b1}} : prog_data[BW-1:0];
        end
        2'd2: for (int i = 0; i < NW; i++) mem[i] <= {DW{1'b1}};
        default: for (int i = 0; i < NW; i++)
          mem[i] <= p_byte ? {prog_data[BW-1:0], prog_data[BW-1:0]} : prog_data;
      endcase
    end
  end

  a_r11_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> !dout_oe);
  a_r3_first_bit_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout);
  a_r10_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && !prog_done |=> prog_req && $stable(prog_addr) && $stable(prog_kind));
  a_r9_request_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_req) |-> wen);
endmodule

// File: tb/sim_mw_eeprom_front.sv
module sim_mw_eeprom_front;
  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0, org_byte = 0, prog_done = 0;
  logic dout, dout_oe, prog_req;
  logic [1:0] prog_kind;
  logic [8:0] prog_addr;
  logic [15:0] prog_data;
  int checks = 0, errors = 0;
  logic sdo, soe;
  bit got;
  logic [1:0] k;
  logic [8:0] a;
  logic [15:0] d, v;

  mw_eeprom_front u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org_byte(org_byte),
    .dout(dout), .dout_oe(dout_oe), .prog_req(prog_req), .prog_kind(prog_kind),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_done(prog_done));

  always #5 clk = ~clk;

  localparam logic [23:0] VEC [6] = '{24'hFE_A1B2, 24'hFF_C3D4, 24'h00_0F0F,
                                      24'h01_1234, 24'h11_5A5A, 24'h80_8001};

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b);
    di = b;
    repeat (2) @(negedge clk);
    sk = 1;
    repeat (4) @(negedge clk);
    sdo = dout; soe = dout_oe;
    sk = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] x, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(x[i]);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [8:0] ad, input bit b);
    cs = 1;
    repeat (3) @(negedge clk);
    clk_bit(1'b1);
    clk_bit(op[1]); clk_bit(op[0]);
    for (int i = (b ? 8 : 7); i >= 0; i--) clk_bit(ad[i]);
  endtask

  task automatic getw(output logic [15:0] x, input int n);
    x = 0;
    for (int i = 0; i < n; i++) begin
      clk_bit(1'b0);
      x = {x[14:0], sdo};
    end
  endtask

  task automatic endcs;
    cs = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic service(output bit g, output logic [1:0] kk, output logic [8:0] aa, output logic [15:0] dd);
    g = 0;
    for (int i = 0; i < 40 && !g; i++) begin
      if (prog_req) g = 1;
      else @(negedge clk);
    end
    kk = prog_kind; aa = prog_addr; dd = prog_data;
    if (g) begin
      repeat (3) @(negedge clk);
      prog_done = 1;
      @(negedge clk);
      prog_done = 0;
      @(negedge clk);
    end
  endtask

  task automatic rd16(input logic [7:0] ad, input logic [15:0] exp, input string r);
    logic [15:0] x;
    cmd(2'b10, {1'b0, ad}, 0);
    chk(soe && sdo == 0, {r, " dummy zero"}, {soe, sdo}, 2'b10);
    getw(x, 16);
    chk(x == exp, {r, " read data"}, x, exp);
    endcs;
  endtask

  task automatic no_req(input string r);
    repeat (30) @(negedge clk);
    chk(prog_req == 0, r, prog_req, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout_oe == 0 && prog_req == 0, "R1 reset outputs", {dout_oe, prog_req}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 R9: latch clear after reset, write ignored
    cmd(2'b01, 9'h005, 0); send(16'hDEAD, 16); endcs;
    no_req("R1 R9 write ignored before enable");

    // R2: leading zeros then enable (00 + 11)
    cs = 1; repeat (3) @(negedge clk);
    clk_bit(0); clk_bit(0); clk_bit(0);
    cmd(2'b00, 9'h0C0, 0); endcs;
    // R8: erase-all
    cmd(2'b00, 9'h080, 0); endcs;
    service(got, k, a, d);
    chk(got && k == 2, "R2 R8 erase-all request after leading zeros", {got, k}, 3'b110);
    rd16(8'h37, 16'hFFFF, "R8 erase-all contents");

    // table of writes then read-backs (R6 R3)
    for (int i = 0; i < 6; i++) begin
      cmd(2'b01, {1'b0, VEC[i][23:16]}, 0); send(VEC[i][15:0], 16); endcs;
      service(got, k, a, d);
      chk(got && k == 0 && a == {1'b0, VEC[i][23:16]} && d == VEC[i][15:0],
          "R6 write request fields", {got, k, a, d}, {1'b1, 2'd0, 1'b0, VEC[i]});
      rd16(VEC[i][23:16], VEC[i][15:0], "R3 R6 read back");
    end

    // R4: sequential read with wrap
    cmd(2'b10, 9'h0FE, 0);
    chk(soe && sdo == 0, "R4 R3 dummy before first word", {soe, sdo}, 2'b10);
    getw(v, 16); chk(v == 16'hA1B2, "R4 word 254", v, 16'hA1B2);
    getw(v, 16); chk(v == 16'hC3D4, "R4 word 255 without dummy", v, 16'hC3D4);
    getw(v, 16); chk(v == 16'h0F0F, "R4 wrap to word 0", v, 16'h0F0F);
    getw(v, 16); chk(v == 16'h1234, "R4 word 1", v, 16'h1234);
    endcs;

    // R7: erase
    cmd(2'b11, 9'h011, 0); endcs;
    service(got, k, a, d);
    chk(got && k == 1 && a == 9'h011, "R7 erase request", {got, k, a}, {1'b1, 2'd1, 9'h011});
    rd16(8'h11, 16'hFFFF, "R7 erased word");

    // R5: byte organization
    org_byte = 1; repeat (4) @(negedge clk);
    cmd(2'b01, 9'h003, 1); send(16'h00A5, 8); endcs;
    service(got, k, a, d);
    chk(got && k == 0 && a == 9'h003 && d == 16'h00A5, "R5 byte write request", {got, k, a, d}, {1'b1, 2'd0, 9'h003, 16'h00A5});
    cmd(2'b10, 9'h002, 1);
    chk(soe && sdo == 0, "R5 byte read dummy", {soe, sdo}, 2'b10);
    getw(v, 8); chk(v[7:0] == 8'h34, "R5 low byte of word 1", v[7:0], 8'h34);
    getw(v, 8); chk(v[7:0] == 8'hA5, "R5 R4 upper byte written", v[7:0], 8'hA5);
    endcs;
    cmd(2'b10, 9'h1FF, 1);
    getw(v, 8); chk(v[7:0] == 8'hC3, "R5 top byte", v[7:0], 8'hC3);
    getw(v, 8); chk(v[7:0] == 8'h0F, "R5 R4 byte wrap to 0", v[7:0], 8'h0F);
    endcs;
    org_byte = 0; repeat (4) @(negedge clk);
    rd16(8'h01, 16'hA534, "R5 word after byte write");

    // R8: write-all
    cmd(2'b00, 9'h040, 0); send(16'hBEEF, 16); endcs;
    service(got, k, a, d);
    chk(got && k == 3 && d == 16'hBEEF, "R8 write-all request", {got, k, d}, {1'b1, 2'd3, 16'hBEEF});
    rd16(8'h21, 16'hBEEF, "R8 write-all contents");

    // R10: overlapping command dropped
    cmd(2'b01, 9'h020, 0); send(16'h1357, 16); endcs;
    repeat (5) @(negedge clk);
    cmd(2'b01, 9'h021, 0); send(16'h2468, 16); endcs;
    repeat (10) @(negedge clk);
    chk(prog_req && prog_addr == 9'h020 && prog_data == 16'h1357, "R10 request held",
        {prog_req, prog_addr, prog_data}, {1'b1, 9'h020, 16'h1357});
    service(got, k, a, d);
    no_req("R10 second command dropped");
    rd16(8'h21, 16'hBEEF, "R10 dropped write left word");

    // R9: disable then program commands ignored, reads work
    cmd(2'b00, 9'h000, 0); endcs;
    cmd(2'b01, 9'h020, 0); send(16'h0000, 16); endcs;
    no_req("R9 write ignored when disabled");
    cmd(2'b00, 9'h080, 0); endcs;
    no_req("R9 erase-all ignored when disabled");
    rd16(8'h20, 16'h1357, "R9 read while disabled");

    // R11: aborted command, then clean decode
    cs = 1; repeat (3) @(negedge clk);
    clk_bit(1); clk_bit(1); clk_bit(0); clk_bit(1);
    endcs;
    rd16(8'h20, 16'h1357, "R11 fresh decode after abort");
    cmd(2'b10, 9'h020, 0); getw(v, 4); endcs;
    chk(dout_oe == 0, "R11 output released on deselect", dout_oe, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule